// File: doc/BRIEF.md
# Directional Pad Combination Filter

This block accepts one button byte per frame from a game controller and removes direction combinations that a worn pad can produce but a program should not see. A frame strobe marks each new byte. Two policies are available. The first rejects opposing presses, meaning up with down or left with right. The second rejects any diagonal, so the pad behaves like a 4-way stick.

When a frame is rejected, the action buttons still take their new values. The four direction bits are held at the previous frame's filtered value. The block keeps that filtered byte as its history. From it, the block also produces two masks for each frame: buttons newly pressed and buttons newly released.

All three outputs are registered. They change only on a frame strobe and stay valid until the next one. The block serves one controller. It expects an already assembled, already debounced byte.

Top module: `dpad_filter`

## Requirements
- R1: Button bit positions are A=7, B=6, Select=5, Start=4, Up=3, Down=2, Left=1, Right=0. On every frame strobe, filtered bits 7..4 take raw bits 7..4, whether or not the frame is rejected.
- R2: With `mode_four_way`=0 (opposing policy), a frame is rejected exactly when Up and Down are both set, or Left and Right are both set.
- R3: With `mode_four_way`=1 (4-way policy), a frame is rejected exactly when two or more of raw bits 3..0 are set.
- R4: On a rejected frame, filtered bits 3..0 keep the filtered bits 3..0 of the previous frame (0 right after reset).
- R5: On an accepted frame, the filtered output equals the raw byte.
- R6: The pressed mask equals new filtered AND NOT previous filtered. It is never set for a bit that is also set in the released mask.
- R7: The released mask equals previous filtered AND NOT new filtered.
- R8: Synchronous reset clears the filtered byte, both masks and the history to 0x00.
- R9: Without a frame strobe, all outputs hold their values, whatever the raw input does.
- R10: A change of `mode_four_way` between strobes alters no output and no history. It applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe: raw_btn holds a new frame |
| mode_four_way | input | 1 | 0 = opposing-press rejection, 1 = diagonal rejection |
| raw_btn | input | 8 | Raw button byte, 1 = pressed |
| filt_btn | output | 8 | Filtered button byte (also the history) |
| press_mask | output | 8 | Buttons newly pressed in the last frame |
| release_mask | output | 8 | Buttons newly released in the last frame |

## Verification
The history and the filtered output are the same register. A corrupted history therefore shows at `filt_btn` in the cycle after the strobe that wrote it. It then propagates into the edge masks and into the held directions of the next rejected frame. A wrong reject decision shows up one cycle after that strobe, as direction bits that either follow or ignore the raw byte. A mask error that survives to the following strobe indicates wrong hold behaviour. The frame sequences are chained so that each frame's expected masks depend on the previous frame's filtered value.

// File: rtl/dpad_pkg.sv
package dpad_pkg;
  localparam int BTN_W = 8;
  localparam int DIR_W = 4;

  typedef enum logic {
    MODE_OPPOSING = 1'b0,
    MODE_FOUR_WAY = 1'b1
  } dpad_mode_e;
endpackage

// File: rtl/dpad_reject_check.sv
module dpad_reject_check #(
  parameter int DIR_W = dpad_pkg::DIR_W
) (
  input  logic             four_way,
  input  logic [DIR_W-1:0] dirs,
  output logic             reject
);
  localparam int PAIRS = DIR_W / 2;

  logic [PAIRS-1:0] pair_clash;
  logic             multi_dir;

  // each pair is (odd bit, even bit) = (Up,Down) / (Left,Right)
  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign pair_clash[g] = dirs[2*g+1] & dirs[2*g];
  end

  // more than one bit set when clearing the lowest set bit leaves something
  assign multi_dir = |(dirs & (dirs - DIR_W'(1)));

  always_comb begin
    if (dpad_pkg::dpad_mode_e'(four_way) == dpad_pkg::MODE_FOUR_WAY)
      reject = multi_dir;
    else
      reject = |pair_clash;
  end
endmodule

// File: rtl/dpad_merge.sv
module dpad_merge #(
  parameter int BTN_W = dpad_pkg::BTN_W,
  parameter int DIR_W = dpad_pkg::DIR_W
) (
  input  logic [BTN_W-1:0] raw,
  input  logic [BTN_W-1:0] prev,
  input  logic             reject,
  output logic [BTN_W-1:0] merged
);
  localparam int ACT_W = BTN_W - DIR_W;

  logic [ACT_W-1:0] act_part;
  logic [DIR_W-1:0] dir_part;

  assign act_part = raw[BTN_W-1:DIR_W];
  assign dir_part = reject ? prev[DIR_W-1:0] : raw[DIR_W-1:0];
  assign merged   = {act_part, dir_part};
endmodule

// File: rtl/dpad_state_reg.sv
module dpad_state_reg #(
  parameter int BTN_W = dpad_pkg::BTN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BTN_W-1:0] next_btn,
  output logic [BTN_W-1:0] hist,
  output logic [BTN_W-1:0] pressed,
  output logic [BTN_W-1:0] released
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      pressed  <= '0;
      released <= '0;
    end else if (load) begin
      hist     <= next_btn;
      pressed  <= next_btn & ~hist;
      released <= hist & ~next_btn;
    end
  end

  p_edges_disjoint_r6: assert property (@(posedge clk) disable iff (rst)
    (pressed & released) == '0);
  p_press_in_current_r6: assert property (@(posedge clk) disable iff (rst)
    (pressed & ~hist) == '0);
  p_release_not_current_r7: assert property (@(posedge clk) disable iff (rst)
    (released & hist) == '0);
  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(hist) && $stable(pressed) && $stable(released)));
endmodule

// File: rtl/dpad_filter.sv
module dpad_filter #(
  parameter int BTN_W = dpad_pkg::BTN_W,
  parameter int DIR_W = dpad_pkg::DIR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_vld,
  input  logic             mode_four_way,
  input  logic [BTN_W-1:0] raw_btn,
  output logic [BTN_W-1:0] filt_btn,
  output logic [BTN_W-1:0] press_mask,
  output logic [BTN_W-1:0] release_mask
);
  localparam int ACT_W = BTN_W - DIR_W;

  logic             reject;
  logic [BTN_W-1:0] merged;
  logic [BTN_W-1:0] hist;

  dpad_reject_check #(.DIR_W(DIR_W)) chk_i (
    .four_way (mode_four_way),
    .dirs     (raw_btn[DIR_W-1:0]),
    .reject   (reject)
  );

  dpad_merge #(.BTN_W(BTN_W), .DIR_W(DIR_W)) mrg_i (
    .raw    (raw_btn),
    .prev   (hist),
    .reject (reject),
    .merged (merged)
  );

  dpad_state_reg #(.BTN_W(BTN_W)) st_i (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_vld),
    .next_btn (merged),
    .hist     (hist),
    .pressed  (press_mask),
    .released (release_mask)
  );

  assign filt_btn = hist;

  p_action_follow_r1: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> filt_btn[BTN_W-1:DIR_W] == $past(raw_btn[BTN_W-1:DIR_W]));
  p_reject_holds_dirs_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && reject) |=> filt_btn[DIR_W-1:0] == $past(filt_btn[DIR_W-1:0]));
  p_accept_copies_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !reject) |=> filt_btn == $past(raw_btn));
  p_four_way_single_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && mode_four_way && $countones(raw_btn[DIR_W-1:0]) <= 1)
      |=> filt_btn[DIR_W-1:0] == $past(raw_btn[DIR_W-1:0]));
endmodule

// File: tb/dpad_filter_tb_top.sv
`timescale 1ns/1ps
module dpad_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       frame_vld;
  logic       mode_four_way;
  logic [7:0] raw_btn;
  logic [7:0] filt_btn, press_mask, release_mask;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dpad_filter dut_i (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .mode_four_way(mode_four_way),
    .raw_btn(raw_btn), .filt_btn(filt_btn), .press_mask(press_mask),
    .release_mask(release_mask)
  );

  // {mode, raw, exp filtered, exp pressed, exp released}; chained from reset
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h81, 8'h81, 8'h81, 8'h00},  // R5 accept
    {1'b0, 8'h49, 8'h49, 8'h48, 8'h80},  // R2 U+R ok
    {1'b0, 8'h2C, 8'h29, 8'h20, 8'h40},  // R2 U+D reject
    {1'b0, 8'h13, 8'h19, 8'h10, 8'h20},  // R2 L+R reject
    {1'b1, 8'h05, 8'h09, 8'h00, 8'h10},  // R3 diagonal reject
    {1'b1, 8'h84, 8'h84, 8'h84, 8'h09},  // R3 single ok
    {1'b1, 8'h0F, 8'h04, 8'h00, 8'h80},  // R3 all dirs
    {1'b0, 8'h0A, 8'h0A, 8'h0A, 8'h04},  // R2 diagonal allowed
    {1'b0, 8'hFF, 8'hFA, 8'hF0, 8'h00},  // R4 R1 all set
    {1'b1, 8'h00, 8'h00, 8'h00, 8'hFA},  // R7 release all
    {1'b1, 8'h02, 8'h02, 8'h02, 8'h00},  // R6
    {1'b0, 8'h06, 8'h06, 8'h04, 8'h00}   // R6 D+L
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check3(input string req, input logic [7:0] f, input logic [7:0] p,
                        input logic [7:0] r);
    check({req, " filt"}, filt_btn, f);
    check({req, " press"}, press_mask, p);
    check({req, " release"}, release_mask, r);
  endtask

  task automatic do_frame(input logic m, input logic [7:0] raw);
    @(negedge clk);
    mode_four_way = m;
    raw_btn = raw;
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    frame_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_vld = 1'b0; mode_four_way = 1'b0; raw_btn = 8'hFF;
    do_reset();
    check3("R8 reset", 8'h00, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      do_frame(VEC[i][32], VEC[i][31:24]);
      check3($sformatf("vec%0d R1..R7", i), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R9: raw wiggles without strobe, outputs hold
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      raw_btn = 8'h3C ^ 8'(k * 37);
    end
    @(negedge clk);
    check3("R9 hold", 8'h06, 8'h04, 8'h00);

    // R10: mode flip without strobe changes nothing; next strobe uses new mode
    mode_four_way = 1'b1;
    raw_btn = 8'h09;
    repeat (3) @(negedge clk);
    check3("R10 no strobe", 8'h06, 8'h04, 8'h00);
    do_frame(1'b1, 8'h09);  // diagonal under 4-way -> dirs from 0x06
    check3("R10 R3 new mode", 8'h06, 8'h00, 8'h00);
    do_frame(1'b0, 8'h09);  // same byte accepted under opposing
    check3("R10 R2 new mode", 8'h09, 8'h09, 8'h06);

    // R8 then R4: first frame rejected takes dirs from cleared history
    do_reset();
    check3("R8 reset again", 8'h00, 8'h00, 8'h00);
    do_frame(1'b0, 8'h3C);
    check3("R4 after reset", 8'h30, 8'h30, 8'h00);

    // R1: action bits update on a rejected 4-way frame
    do_frame(1'b1, 8'hC3);
    check3("R1 reject action", 8'hC0, 8'hC0, 8'h30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule